// File: doc/BRIEF.md
# Scan Line Doubler

This block turns a slow monochrome raster, with lines at roughly 24 kHz and frames at 60 Hz, into a raster with twice as many lines per frame. A standard LCD monitor will accept the result. The input side runs on the input pixel clock and accepts 8-bit gray pixels with a valid strobe, a line sync and a frame sync. The output side runs on a clock at exactly twice that rate, normally taken from a 2:1 PLL. It regenerates its own line sync and sends each captured line twice in a row. A source of about 512×384 therefore comes out as about 512×768 at the same frame rate.

Two line stores work in turns. One fills from the input while the other is played back, once and then a second time, at the doubled pixel rate. The stores change roles on each rising input line sync. The output picks up the newly filled store at its next line boundary. The output line length is set at run time as four counts of output clocks: active pixels, front porch, sync width and back porch. Frame sync is carried through one input line late, so that it stays attached to the doubled data.

Top module: `line_doubler`

## Requirements
- R1: Each captured input line appears on the output as two consecutive output lines with identical pixels. A source line of N valid pixels shows as N enabled output pixels, in order. No line is skipped or repeated beyond two.
- R2: A filled line store is handed to the output before the next input line completes. Writing the next line never disturbs the line being played back.
- R3: A rising edge of `in_hs` ends the current capture. The first `in_valid` pixel after it goes to position 0, and pixels with `in_valid` low are not captured.
- R4: `out_vs` is high for both output copies of an input line during which `in_vs` was high when that line's opening `in_hs` edge occurred. It is low for all other lines and does not change while `out_hs` is high.
- R5: `out_hs` is active-high and free-running. Its period is `cfg_act+cfg_fp+cfg_sw+cfg_bp` output clocks and its width is `cfg_sw`. It rises `cfg_act+cfg_fp` clocks after the first enabled pixel of a line, and is never high together with `out_de`.
- R6: Whenever `out_de` is low, `out_pix` is 0 (black). Positions past a short line's length are black.
- R7: Pixels at or beyond `cfg_act` in a line are not shown. Input pixels beyond the store depth are dropped.
- R8: The frame rate is preserved. Consecutive rising edges of `out_vs` are exactly twice as many output lines apart as the input frame has lines, and `out_vs` stays high for two output lines per one-line input frame sync.
- R9: After reset, and after the two copies of the last captured line when no new line arrives, output lines carry no enabled pixels and `out_vs` stays low, while `out_hs` keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input pixel clock |
| clk_out | input | 1 | Output pixel clock, twice clk_in |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| in_valid | input | 1 | Input pixel strobe |
| in_pix | input | PIX_W | Input gray level |
| in_hs | input | 1 | Input line sync, rising edge starts a line |
| in_vs | input | 1 | Input frame sync level |
| cfg_act | input | HW | Active pixels per output line |
| cfg_fp | input | HW | Front porch, output clocks |
| cfg_sw | input | HW | Sync width, output clocks |
| cfg_bp | input | HW | Back porch, output clocks |
| out_de | output | 1 | Output pixel enable |
| out_pix | output | PIX_W | Output gray level, 0 when blank |
| out_hs | output | 1 | Regenerated line sync, active high |
| out_vs | output | 1 | Frame sync, one input line late |

## Verification
The in-line assertions check four properties on every output clock:
- blanking forces black;
- sync and enable never overlap;
- frame sync holds still during a sync pulse;
- a new filled line never arrives while the previous one is still waiting.

The ordering and duplication of lines, and the pixel contents and line lengths, are shown only by the bench's scenarios. The same holds for the exact porch and period counts, the one-line lag of frame sync, the frame spacing and the idle behaviour after input stops. These scenarios compare every output line against arithmetically generated input lines of full, short and over-long lengths.

// File: rtl/line_doubler.sv
module line_doubler #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 1024,
  parameter int HW    = 12
) (
  input  logic             clk_in,
  input  logic             clk_out,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PIX_W-1:0] in_pix,
  input  logic             in_hs,
  input  logic             in_vs,
  input  logic [HW-1:0]    cfg_act,
  input  logic [HW-1:0]    cfg_fp,
  input  logic [HW-1:0]    cfg_sw,
  input  logic [HW-1:0]    cfg_bp,
  output logic             out_de,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_hs,
  output logic             out_vs
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [PIX_W-1:0] store0 [DEPTH];
  logic [PIX_W-1:0] store1 [DEPTH];

  // capture side
  logic          hs_d, wsel, cur_vs, done_vs, done_sel, tgl_in;
  logic [LW-1:0] wr_cnt, done_len;

  wire hs_edge = in_hs & ~hs_d;
  wire wr_ok   = in_valid && !hs_edge && (wr_cnt < LW'(DEPTH));

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      hs_d     <= 1'b0;
      wsel     <= 1'b0;
      cur_vs   <= 1'b0;
      done_vs  <= 1'b0;
      done_sel <= 1'b0;
      tgl_in   <= 1'b0;
      wr_cnt   <= '0;
      done_len <= '0;
    end else begin
      hs_d <= in_hs;
      if (hs_edge) begin
        wsel     <= ~wsel;
        done_sel <= wsel;
        done_len <= wr_cnt;
        done_vs  <= cur_vs;
        cur_vs   <= in_vs;
        wr_cnt   <= '0;
        tgl_in   <= ~tgl_in;
      end else if (wr_ok) begin
        wr_cnt <= wr_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_in) begin
    if (wr_ok && wsel)  store1[wr_cnt[AW-1:0]] <= in_pix;
    if (wr_ok && !wsel) store0[wr_cnt[AW-1:0]] <= in_pix;
  end

  // playback side
  logic [2:0]    tsync;
  logic          pend, line_on, rep, rd_sel, rd_vs;
  logic [LW-1:0] rd_len;
  logic [HW-1:0] h_cnt;

  wire new_evt = tsync[2] ^ tsync[1];
  wire avail   = pend | new_evt;

  wire [HW-1:0] hs_on  = cfg_act + cfg_fp;
  wire [HW-1:0] hs_off = hs_on + cfg_sw;
  wire [HW-1:0] h_tot  = hs_off + cfg_bp;
  wire          h_end  = (h_cnt == h_tot - HW'(1));

  wire de_c = line_on && (32'(h_cnt) < 32'(rd_len)) && (h_cnt < cfg_act);
  wire hs_c = (h_cnt >= hs_on) && (h_cnt < hs_off);
  wire [PIX_W-1:0] rdata = rd_sel ? store1[h_cnt[AW-1:0]] : store0[h_cnt[AW-1:0]];

  always_ff @(posedge clk_out or negedge rst_n) begin
    if (!rst_n) begin
      tsync   <= '0;
      pend    <= 1'b0;
      line_on <= 1'b0;
      rep     <= 1'b0;
      rd_sel  <= 1'b0;
      rd_vs   <= 1'b0;
      rd_len  <= '0;
      h_cnt   <= '0;
      out_de  <= 1'b0;
      out_pix <= '0;
      out_hs  <= 1'b0;
      out_vs  <= 1'b0;
    end else begin
      tsync <= {tsync[1:0], tgl_in};
      pend  <= avail & ~h_end;
      h_cnt <= h_end ? '0 : h_cnt + 1'b1;
      if (h_end) begin
        if (avail) begin
          line_on <= 1'b1;
          rep     <= 1'b0;
          rd_sel  <= done_sel;
          rd_len  <= done_len;
          rd_vs   <= done_vs;
        end else if (line_on && !rep) begin
          rep <= 1'b1;
        end else begin
          line_on <= 1'b0;
        end
      end
      out_de  <= de_c;
      out_pix <= de_c ? rdata : '0;
      out_hs  <= hs_c;
      out_vs  <= line_on & rd_vs;
    end
  end

  a_r2_no_lost_line: assert property (@(posedge clk_out) disable iff (!rst_n)
    new_evt |-> !pend);
  a_r6_black_blank: assert property (@(posedge clk_out) disable iff (!rst_n)
    !out_de |-> (out_pix == '0));
  a_r5_sync_not_active: assert property (@(posedge clk_out) disable iff (!rst_n)
    out_hs |-> !out_de);
  a_r4_vs_steady_in_sync: assert property (@(posedge clk_out) disable iff (!rst_n)
    (out_hs && $past(out_hs)) |-> $stable(out_vs));
endmodule

// File: tb/tb_line_doubler.sv
module tb_line_doubler;
  logic clk_out = 1'b0;
  logic clk_in  = 1'b0;
  logic rst_n   = 1'b0;
  always #4 clk_out = ~clk_out;
  always @(posedge clk_out) clk_in <= ~clk_in;

  logic       in_valid = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
  logic [7:0] in_pix = 8'h00;
  logic [7:0] cfg_act = 8'd32, cfg_fp = 8'd4, cfg_sw = 8'd6, cfg_bp = 8'd6;
  logic       out_de, out_hs, out_vs;
  logic [7:0] out_pix;

  line_doubler #(.PIX_W(8), .DEPTH(64), .HW(8)) dut (
    .clk_in(clk_in), .clk_out(clk_out), .rst_n(rst_n),
    .in_valid(in_valid), .in_pix(in_pix), .in_hs(in_hs), .in_vs(in_vs),
    .cfg_act(cfg_act), .cfg_fp(cfg_fp), .cfg_sw(cfg_sw), .cfg_bp(cfg_bp),
    .out_de(out_de), .out_pix(out_pix), .out_hs(out_hs), .out_vs(out_vs));

  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, int actv, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
    end
  endtask

  function automatic logic [7:0] pf(int g, int x);
    return 8'(g * 37 + x * 11 + 3);
  endfunction

  int exp_len [64];
  bit exp_vs  [64];
  int ng = 0;

  task automatic drive_line(int len, bit vs);
    int g;
    g = ng;
    exp_len[ng] = (len > 32) ? 32 : len;
    exp_vs[ng]  = vs;
    ng++;
    for (int c = 0; c < 48; c++) begin
      @(negedge clk_in);
      in_hs    = (c < 4);
      in_vs    = vs;
      in_valid = (c >= 5) && (c < 5 + len);
      in_pix   = in_valid ? pf(g, c - 5) : 8'hEE;
    end
  endtask

  // output monitor
  int  cyc = 0, lcnt = 0, j = 0;
  int  t_hs = 0, t_de = 0, t_vs = 0;
  bit  have_hs = 0, have_vs = 0, synced = 0, black_bad = 0;
  bit  p_hs = 0, p_de = 0, p_vs = 0;
  logic [7:0] lbuf [64];

  always @(negedge clk_out) begin
    if (rst_n) begin
      cyc++;
      if (out_de) begin
        if (lcnt < 64) lbuf[lcnt] = out_pix;
        lcnt++;
        if (!p_de) t_de = cyc;
      end else if (out_pix != 8'h00) begin
        black_bad = 1'b1;
      end
      if (out_hs && !p_hs) begin
        if (have_hs) chk(cyc - t_hs == 48, "R5 line period", cyc - t_hs, 48);
        if (lcnt > 0) chk(cyc - t_de == 36, "R5 sync position", cyc - t_de, 36);
        chk(!black_bad, "R6 black outside active", int'(black_bad), 0);
        if (!synced && lcnt > 0) synced = 1'b1;
        if (synced) begin
          int g;
          bit ok;
          g = j / 2;
          if (g < ng) begin
            ok = (lcnt == exp_len[g]);
            for (int x = 0; x < lcnt && x < 64; x++)
              if (lbuf[x] != pf(g, x)) ok = 1'b0;
            chk(ok, "R1 R3 R7 doubled line content", lcnt, exp_len[g]);
            chk(out_vs == exp_vs[g], "R4 vsync per line", int'(out_vs), int'(exp_vs[g]));
          end else begin
            chk(lcnt == 0 && !out_vs, "R9 idle line blank", lcnt, 0);
          end
          j++;
        end
        t_hs = cyc;
        have_hs = 1'b1;
        lcnt = 0;
        black_bad = 1'b0;
      end
      if (!out_hs && p_hs) chk(cyc - t_hs == 6, "R5 sync width", cyc - t_hs, 6);
      if (out_vs && !p_vs) begin
        if (have_vs) chk(cyc - t_vs == 960, "R8 frame spacing", cyc - t_vs, 960);
        t_vs = cyc;
        have_vs = 1'b1;
      end
      if (!out_vs && p_vs) chk(cyc - t_vs == 96, "R8 vsync length", cyc - t_vs, 96);
      p_hs = out_hs;
      p_de = out_de;
      p_vs = out_vs;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_out);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk_out);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_out);
    chk(out_de == 0 && out_pix == 0, "R9 reset blank", int'(out_pix), 0);
    chk(out_vs == 0, "R9 reset vsync", int'(out_vs), 0);
    // frame 0: full lines
    for (int k = 0; k < 10; k++) drive_line(32, k == 0);
    // frame 1: short and over-long lines
    for (int k = 0; k < 10; k++) drive_line((k % 2 == 0) ? 20 : 40, k == 0);
    // frame 2: growing lengths
    for (int k = 0; k < 10; k++) drive_line(10 + 2 * k, k == 0);
    drive_line(0, 1'b0);
    @(negedge clk_in);
    in_hs = 1'b0; in_valid = 1'b0; in_vs = 1'b0;
    repeat (800) @(negedge clk_out);
    chk(j >= 2 * ng + 4, "R1 R9 all lines out then idle", j, 2 * ng + 4);
    chk(synced, "R1 output started", int'(synced), 1);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule